// File: doc/BRIEF.md
# Configurable SPI Serial Engine

This block moves parallel words over a four-wire synchronous serial link in the clock-polarity/clock-phase frame format commonly called SPI. Software-style configuration writes set the word length (4 to 16 bits), the idle level of the serial clock, which clock edge samples and which edge launches data, the bit rate, an internal loopback path, the port enable and the master or slave role. In master mode the block makes the serial clock from the system clock through a two-stage divider and drives an active-low frame select. In slave mode it follows an external serial clock and select.

A word to send is offered on a valid/ready handshake. Every completed frame returns the received word, right-aligned, with a one-cycle valid strobe. Data travels MSB first. Only the SPI frame format is supported. The other frame-format codes are accepted into the register, but with any of them the port makes no frames.

Configuration map (write-only, `cfg_addr`): 0 is the format word, 1 is the mode word, 2 is the prescaler. All three reset to zero.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, all configuration is zero. The port is therefore disabled: `tx_ready`=0, `sel_n_out`=1, `sclk_out`=0, `ser_out`=0 and `rx_valid`=0.
- R2: Format word bits [11:8] hold a size code. Codes 3 to 15 give a word length of code+1 bits. Codes 0 to 2 are reserved, and while one of them is set no frame starts (`tx_ready` stays 0).
- R3: Format word bits [13:12] hold the frame-format code. Only 00 makes frames. With 01, 10 or 11 no frame starts.
- R4: Format word bit 14 is the clock polarity. The serial clock rests at that level between frames, and a master frame ends with the clock back at that level. The leading edge of a bit period is the edge away from the rest level.
- R5: Format word bit 15 is the phase. With phase 0 the MSB is on `ser_out` from the moment select goes low; data is sampled on leading edges and the next bit is launched on trailing edges. With phase 1 the data is launched on leading edges (the first one keeps the MSB) and sampled on trailing edges. Within a master frame, `ser_out` changes only together with a serial clock edge.
- R6: Format word bits [7:0] hold the rate factor R, and the prescaler word [7:0] holds P. Bit 0 of P is ignored, and a P below 2 counts as 2. In master mode every serial clock half period lasts (P/2)*(1+R) system clocks, so each bit lasts P*(1+R) clocks.
- R7: P and R are taken when a frame starts. A write to them during a frame changes only later frames.
- R8: Mode word bit 2 selects loopback. When it is set, the receiver takes the transmitter's own output and ignores `ser_in`.
- R9: Mode word bit 0 enables the port. While it is 0 no frame starts. Clearing it during a frame ends the frame at once: select goes high and no received word is reported.
- R10: Mode word bit 1 selects the role (0 master, 1 slave). A write changes this bit only if the port was disabled before the write.
- R11: Data is shifted MSB first. After the last serial clock edge of a frame, `rx_valid` is high for exactly one cycle. At that point `rx_data` holds the received word in its low bits, with all higher bits zero. Transmit bits above the word length are not sent.
- R12: In slave mode the block waits for `sel_n_in` low and then takes a transmit word. It launches and samples on the edges of `sclk_in`, following R4 and R5, and reports the word after the last edge. `sclk_out` and `sel_n_out` stay at rest.
- R13: In master mode, `tx_ready` is high only while the port is idle, enabled and validly configured. Select falls in the cycle after a handshake. `tx_ready` is high again in the cycle in which the frame's word is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select (0 format, 1 mode, 2 prescaler) |
| cfg_wdata | input | 16 | Configuration write data |
| tx_data | input | DATA_W | Word to transmit, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine accepts the word this cycle |
| rx_data | output | DATA_W | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sel_n_out | output | 1 | Active-low frame select driven in master mode |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |
| sclk_in | input | 1 | Serial clock from an external master |
| sel_n_in | input | 1 | Frame select from an external master |

## Verification
The assertions check several relations on every cycle. Select may only fall after an accepted handshake. The ready signal is only high for a legal frame-format and size code. A received-word strobe lasts a single cycle, and the word has no bits set above the frame length. Serial data never moves in a master frame without a clock edge. A disabled port must come to rest, and the role bit holds while the port is enabled. The exact placement of each clock edge in system cycles, bit order under each polarity and phase, loopback, capture of the rate at frame start and the whole slave exchange are shown by the bench's scenarios. There, a behavioural model predicts clock, select and data for every cycle.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int REG_W  = 16;
  localparam int RATE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } shift_st_t;

  // format word, MSB first: phase, polarity, frame code, size code, rate
  typedef struct packed {
    logic              cpha;
    logic              cpol;
    logic [1:0]        fcode;
    logic [3:0]        size;
    logic [RATE_W-1:0] rate;
  } fmt_reg_t;

  typedef struct packed {
    logic lb;
    logic role;
    logic en;
  } mode_reg_t;

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output fmt_reg_t         fmt,
  output mode_reg_t        mode,
  output logic [PSC_W-1:0] psc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt  <= '0;
      mode <= '0;
      psc  <= '0;
    end else if (we) begin
      case (addr)
        2'd0: fmt <= fmt_reg_t'(wdata);
        2'd1: begin
          mode.en <= wdata[0];
          mode.lb <= wdata[2];
          // role may only move while the port is off
          if (!mode.en) mode.role <= wdata[1];
        end
        2'd2: psc <= {wdata[PSC_W-1:1], 1'b0};
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
  parameter int PSC_W  = 8,
  parameter int RATE_W = 8,
  localparam int HW    = PSC_W + RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run,
  input  logic [PSC_W-1:0]  psc,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [HW-1:0]    half_q, cnt_q, half_d;
  logic [PSC_W-1:0] pe;

  always_comb begin
    pe = psc >> 1;
    if (pe == '0) pe = PSC_W'(1);
    half_d = HW'(pe) * (HW'(rate) + HW'(1));
  end

  assign tick = run && (cnt_q == half_q - HW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HW'(1);
      cnt_q  <= '0;
    end else if (start) begin
      half_q <= half_d;
      cnt_q  <= '0;
    end else if (run) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + HW'(1);
    end
  end

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LW    = $clog2(DATA_W) + 1,
  localparam int EW    = LW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              role,
  input  logic              lb,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [3:0]        size,
  input  logic [1:0]        fcode,
  input  logic              tick,
  input  logic              sclk_s,
  input  logic              sel_s,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              start,
  output logic              run_m,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sclk_out,
  output logic              sel_n_out,
  output logic              ser_out,
  input  logic              ser_in,
  output logic [LW-1:0]     len_out
);

  shift_st_t         st;
  logic [EW-1:0]     edge_q;
  logic [LW-1:0]     len_q, len_d;
  logic              cpha_q, lb_q, master_q, sclk_prev;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nx;
  logic              ok, ev, smp, shf, last, in_bit;

  assign ok       = en && (fcode == 2'b00) && (size >= 4'd3);
  assign tx_ready = (st == ST_IDLE) && ok && (!role || !sel_s);
  assign start    = (st == ST_IDLE) && ok && (role ? !sel_s : tx_valid);
  assign run_m    = (st == ST_RUN) && master_q;

  assign len_d  = LW'(size) + LW'(1);
  assign ev     = master_q ? tick : (sclk_s ^ sclk_prev);
  assign smp    = (edge_q[0] == cpha_q);
  assign shf    = !smp && (edge_q != '0);
  assign last   = (edge_q == ({len_q, 1'b0} - EW'(1)));
  assign in_bit = lb_q ? tx_sh[DATA_W-1] : ser_in;
  assign rx_nx  = {rx_sh[DATA_W-2:0], in_bit};

  assign ser_out = tx_sh[DATA_W-1];
  assign len_out = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      edge_q    <= '0;
      len_q     <= LW'(DATA_W);
      cpha_q    <= 1'b0;
      lb_q      <= 1'b0;
      master_q  <= 1'b1;
      sclk_prev <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      sclk_out  <= 1'b0;
      sel_n_out <= 1'b1;
    end else begin
      rx_valid  <= 1'b0;
      sclk_prev <= sclk_s;
      case (st)
        ST_IDLE: begin
          sclk_out  <= cpol;
          sel_n_out <= 1'b1;
          tx_sh     <= '0;
          if (start) begin
            st        <= ST_RUN;
            edge_q    <= '0;
            len_q     <= len_d;
            cpha_q    <= cpha;
            lb_q      <= lb;
            master_q  <= !role;
            rx_sh     <= '0;
            sel_n_out <= role;
            tx_sh     <= tx_valid ? (tx_data << (LW'(DATA_W) - len_d)) : '0;
          end
        end
        ST_RUN: begin
          if (!en || (!master_q && sel_s)) begin
            st        <= ST_IDLE;
            sel_n_out <= 1'b1;
            sclk_out  <= cpol;
            tx_sh     <= '0;
          end else if (ev) begin
            if (smp)      rx_sh    <= rx_nx;
            if (shf)      tx_sh    <= tx_sh << 1;
            if (master_q) sclk_out <= ~sclk_out;
            if (last) begin
              rx_valid  <= 1'b1;
              rx_data   <= smp ? rx_nx : rx_sh;
              tx_sh     <= '0;
              sel_n_out <= 1'b1;
              st        <= master_q ? ST_IDLE : ST_HOLD;
            end else begin
              edge_q <= edge_q + EW'(1);
            end
          end
        end
        ST_HOLD: begin
          if (!en || sel_s) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LW         = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sclk_out,
  output logic              sel_n_out,
  output logic              ser_out,
  input  logic              ser_in,
  input  logic              sclk_in,
  input  logic              sel_n_in
);

  fmt_reg_t         fmt;
  mode_reg_t        mode;
  logic [PSC_W-1:0] psc;
  logic             tick, start, run_m;
  logic [1:0]       sync_q;
  logic             cfg_en, cfg_role;
  logic [1:0]       fmt_code;
  logic [3:0]       size_code;
  logic [LW-1:0]    frame_len;

  assign cfg_en    = mode.en;
  assign cfg_role  = mode.role;
  assign fmt_code  = fmt.fcode;
  assign size_code = fmt.size;

  spi_eng_regs #(.PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .fmt(fmt), .mode(mode), .psc(psc)
  );

  spi_eng_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d({sel_n_in, sclk_in}), .q(sync_q)
  );

  spi_eng_baud #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_baud (
    .clk(clk), .rst(rst), .start(start), .run(run_m),
    .psc(psc), .rate(fmt.rate), .tick(tick)
  );

  spi_eng_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .en(mode.en), .role(mode.role), .lb(mode.lb),
    .cpol(fmt.cpol), .cpha(fmt.cpha), .size(fmt.size), .fcode(fmt.fcode),
    .tick(tick), .sclk_s(sync_q[0]), .sel_s(sync_q[1]),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .start(start), .run_m(run_m), .rx_data(rx_data), .rx_valid(rx_valid),
    .sclk_out(sclk_out), .sel_n_out(sel_n_out), .ser_out(ser_out),
    .ser_in(ser_in), .len_out(frame_len)
  );

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
  parameter int DATA_W = 16,
  localparam int LW    = $clog2(DATA_W) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              sel_n_out,
  input logic              sclk_out,
  input logic              ser_out,
  input logic              cfg_en,
  input logic              cfg_role,
  input logic [1:0]        fmt_code,
  input logic [3:0]        size_code,
  input logic [LW-1:0]     frame_len
);

  assert_legal_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (fmt_code == 2'b00 && size_code >= 4'd3));

  assert_select_after_hs_R13: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n_out) |-> $past(tx_valid && tx_ready));

  assert_ready_only_idle_R13: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> sel_n_out);

  assert_rx_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_rx_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> frame_len) == '0));

  assert_data_moves_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (!sel_n_out && $past(!sel_n_out) && !$stable(ser_out)) |-> !$stable(sclk_out));

  assert_off_rests_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (sel_n_out && !rx_valid));

  assert_role_locked_R10: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_en) |-> $stable(cfg_role));

endmodule

bind spi_xfer_engine spi_eng_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .sel_n_out(sel_n_out),
  .sclk_out(sclk_out), .ser_out(ser_out), .cfg_en(cfg_en),
  .cfg_role(cfg_role), .fmt_code(fmt_code), .size_code(size_code),
  .frame_len(frame_len)
);

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid;
  logic        sclk_out, sel_n_out, ser_out;
  logic        ser_in = 1'b0;
  logic        sclk_in = 1'b0;
  logic        sel_n_in = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] fmt_v = '0;

  always #10 clk = ~clk;

  spi_xfer_engine u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .sclk_out(sclk_out), .sel_n_out(sel_n_out), .ser_out(ser_out),
    .ser_in(ser_in), .sclk_in(sclk_in), .sel_n_in(sel_n_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fmtw(input logic cpha, input logic cpol,
                                      input logic [1:0] fc, input logic [3:0] sz,
                                      input logic [7:0] rate);
    return {cpha, cpol, fc, sz, rate};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // master frame with a per-cycle expectation of clock, select and data
  task automatic frame(input logic [15:0] word, input logic [15:0] pat, input int len,
                       input int h, input logic cpol, input logic cpha, input logic lb,
                       input int midrate);
    logic [15:0] mask, exp_rx;
    int bi, sc;
    mask   = (len == 16) ? 16'hFFFF : ((16'h1 << len) - 16'h1);
    exp_rx = (lb ? word : pat) & mask;
    @(negedge clk); tx_data = word; tx_valid = 1'b1;
    chk(tx_ready == 1'b1, "R13 ready when idle", tx_ready, 1);
    @(posedge clk);
    for (int e = 0; e < 2*len; e++) begin
      for (int c = 0; c < h; c++) begin
        @(negedge clk);
        tx_valid = 1'b0; cfg_we = 1'b0;
        bi = (e - int'(cpha)) < 0 ? 0 : (e - int'(cpha)) / 2;
        ser_in = pat[len-1-bi];
        sc = cpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
        chk(sel_n_out == 1'b0, "R13 select low in frame", sel_n_out, 0);
        chk(sclk_out == (cpol ^ e[0]), "R6 clock edge timing", sclk_out, cpol ^ e[0]);
        chk(ser_out == word[len-1-sc], "R5 data bit order", ser_out, word[len-1-sc]);
        chk(rx_valid == 1'b0, "R11 no early strobe", rx_valid, 0);
        if (midrate >= 0 && e == 1 && c == 0) begin
          fmt_v[7:0] = 8'(midrate);
          cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = fmt_v;
        end
      end
    end
    @(negedge clk); cfg_we = 1'b0;
    chk(rx_valid == 1'b1, "R11 strobe after last edge", rx_valid, 1);
    chk(rx_data == exp_rx, lb ? "R8 loopback word" : "R11 received word", rx_data, exp_rx);
    chk(sel_n_out == 1'b1, "R13 select released", sel_n_out, 1);
    chk(sclk_out == cpol, "R4 clock back at rest", sclk_out, cpol);
    chk(ser_out == 1'b0, "R11 data line cleared", ser_out, 0);
    chk(tx_ready == 1'b1, "R13 ready with report", tx_ready, 1);
  endtask

  task automatic no_frame(input string req);
    @(negedge clk); tx_data = 16'h00FF; tx_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(tx_ready == 1'b0 && sel_n_out == 1'b1 && rx_valid == 1'b0, req,
          {tx_ready, sel_n_out, rx_valid}, 3'b010);
    end
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, rxs;
    bit seen, sel_ok;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0; tx_valid = 1'b1;
    @(negedge clk);
    // R1
    chk(tx_ready == 1'b0, "R1 reset ready low", tx_ready, 0);
    chk(sel_n_out == 1'b1, "R1 reset select high", sel_n_out, 1);
    chk(sclk_out == 1'b0, "R1 reset clock low", sclk_out, 0);
    chk(ser_out == 1'b0 && rx_valid == 1'b0, "R1 reset data idle", {ser_out, rx_valid}, 0);
    tx_valid = 1'b0;

    // R6: prescaler 5 reads as 4, rate 1 -> half period 4 clocks
    wr(2'd2, 16'd5);
    fmt_v = fmtw(1'b0, 1'b0, 2'b00, 4'd7, 8'd1); wr(2'd0, fmt_v);
    wr(2'd1, 16'h0001);
    frame(16'h00A5, 16'h003C, 8, 4, 1'b0, 1'b0, 1'b0, -1);

    // R4 R5: polarity 1, phase 1, 12-bit word, upper tx bits dropped
    wr(2'd2, 16'd2);
    fmt_v = fmtw(1'b1, 1'b1, 2'b00, 4'd11, 8'd0); wr(2'd0, fmt_v);
    @(negedge clk);
    chk(sclk_out == 1'b1, "R4 rest level follows polarity", sclk_out, 1);
    frame(16'hFABC, 16'h05A3, 12, 1, 1'b1, 1'b1, 1'b0, -1);

    // R8: loopback ignores ser_in, 16-bit word
    fmt_v = fmtw(1'b0, 1'b1, 2'b00, 4'd15, 8'd0); wr(2'd0, fmt_v);
    wr(2'd1, 16'h0005);
    frame(16'hC3A5, 16'h3C5A, 16, 1, 1'b1, 1'b0, 1'b1, -1);
    wr(2'd1, 16'h0001);

    // R2 R7: 4-bit words, prescaler 0 counts as 2, rate changed mid-frame
    wr(2'd2, 16'd0);
    fmt_v = fmtw(1'b1, 1'b0, 2'b00, 4'd3, 8'd2); wr(2'd0, fmt_v);
    frame(16'h0009, 16'h0006, 4, 3, 1'b0, 1'b1, 1'b0, 9);
    frame(16'h0005, 16'h000A, 4, 10, 1'b0, 1'b1, 1'b0, -1);

    // R2 R3: reserved codes make no frames
    wr(2'd0, fmtw(1'b0, 1'b0, 2'b00, 4'd2, 8'd0)); no_frame("R2 size code 2 reserved");
    wr(2'd0, fmtw(1'b0, 1'b0, 2'b00, 4'd0, 8'd0)); no_frame("R2 size code 0 reserved");
    wr(2'd0, fmtw(1'b0, 1'b0, 2'b01, 4'd7, 8'd0)); no_frame("R3 frame code 01");
    wr(2'd0, fmtw(1'b0, 1'b0, 2'b10, 4'd7, 8'd0)); no_frame("R3 frame code 10");
    wr(2'd0, fmtw(1'b0, 1'b0, 2'b11, 4'd7, 8'd0)); no_frame("R3 frame code 11");

    // R9: disable aborts a running frame
    fmt_v = fmtw(1'b0, 1'b0, 2'b00, 4'd7, 8'd3); wr(2'd0, fmt_v);
    @(negedge clk); tx_data = 16'h0077; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    chk(sel_n_out == 1'b0, "R9 frame under way", sel_n_out, 0);
    repeat (4) @(negedge clk);
    wr(2'd1, 16'h0000);
    @(negedge clk);
    chk(sel_n_out == 1'b1 && sclk_out == 1'b0, "R9 abort to rest", {sel_n_out, sclk_out}, 2'b10);
    seen = 1'b0;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (rx_valid || !sel_n_out) seen = 1'b1;
    end
    chk(!seen, "R9 no report after abort", seen, 0);
    no_frame("R9 disabled port idle");

    // R10: role write ignored while enabled
    wr(2'd1, 16'h0001);
    wr(2'd1, 16'h0003);
    fmt_v = fmtw(1'b0, 1'b0, 2'b00, 4'd7, 8'd0); wr(2'd0, fmt_v);
    frame(16'h0081, 16'h0042, 8, 1, 1'b0, 1'b0, 1'b0, -1);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0002);
    wr(2'd1, 16'h0003);
    no_frame("R10 slave waits for select");

    // R12: slave exchange, external half period 8 clocks
    @(negedge clk); tx_data = 16'h0096; tx_valid = 1'b1; sel_n_in = 1'b0;
    ser_in = 1'b0; // bit 7 of 0x5B
    got = '0; rxs = '0; seen = 1'b0; sel_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (8) begin @(negedge clk); if (!sel_n_out || sclk_out) sel_ok = 1'b0; end
      got[7-i] = ser_out; sclk_in = 1'b1;
      if (i == 0) tx_valid = 1'b0;
      repeat (8) begin @(negedge clk); if (!sel_n_out || sclk_out) sel_ok = 1'b0; end
      sclk_in = 1'b0;
      if (i < 7) ser_in = 8'h5B >> (6 - i);
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (rx_valid && !seen) begin seen = 1'b1; rxs = rx_data[7:0]; end
    end
    sel_n_in = 1'b1;
    chk(got == 8'h96, "R12 slave sent word", got, 8'h96);
    chk(seen, "R12 slave report", seen, 1);
    chk(rxs == 8'h5B, "R12 slave received word", rxs, 8'h5B);
    chk(sel_ok, "R12 outputs at rest in slave", sel_ok, 1);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule